// File: doc/BRIEF.md
# Four-Bit Multifunction Register

This block is a small register with a parallel output and two serial inputs, one feeding the left end and one feeding the right end. On every rising clock edge it rewrites its contents with one of four operations, chosen by a two-bit operation select: add three, shift toward the MSB, invert every bit, or shift toward the LSB. None of the four codes holds the value, so the contents change on every edge while reset is low.

A user steers the register cycle by cycle by presenting the operation code and the serial bits before each edge. To put a known value into the register, the user clears it and then shifts the value in through the right-side serial input, MSB first. There is no parallel load and no carry or overflow flag. The width and the added constant are parameters, and the defaults are 4 and 3.

Top module: `quad_op_reg`

## Requirements
- R1: A high `rst` at a rising edge clears `regOut` to 0000, whatever the operation select and serial inputs are at that edge.
- R2: With `opSel` = 00 at an edge, `regOut` becomes the old value plus three, modulo 16 (13 becomes 0, 14 becomes 1, 15 becomes 2), and no carry is reported.
- R3: With `opSel` = 01 at an edge, every bit moves one place toward the MSB, `serInRight` enters bit 0 and the old bit 3 is dropped.
- R4: With `opSel` = 10 at an edge, `regOut` becomes the bitwise complement of its old value.
- R5: With `opSel` = 11 at an edge, every bit moves one place toward the LSB, `serInLeft` enters bit 3 and the old bit 0 is dropped.
- R6: A serial input that the selected operation does not use has no effect on the result. `serInLeft` is unused for codes 00, 01 and 10, and `serInRight` is unused for codes 00, 10 and 11.
- R7: The operation is taken from the code sampled at each edge, so a code that changes on every cycle applies a different operation at each consecutive edge, with no hold or skipped cycle.
- R8: Inside the block, exactly one operation strobe is active in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| opSel | input | 2 | Operation code: 00 add three, 01 shift toward the MSB, 10 invert, 11 shift toward the LSB |
| serInLeft | input | 1 | Serial bit that enters the MSB on a shift toward the LSB |
| serInRight | input | 1 | Serial bit that enters the LSB on a shift toward the MSB |
| regOut | output | 4 | Register contents |

## Verification
The checker compares each clocked result with the value and code sampled one edge earlier, for every code on every cycle. It also checks the clear after reset and that the decoded strobe set is one-hot. Only the bench scenarios can show the modulo wrap for each of the 16 start values and the way values are built up by chains of shifts. The same holds for codes that change on back-to-back edges, and for the proof, seen at the output, that toggling the serial input a mode does not use leaves the result unchanged.

// File: rtl/quad_op_reg_pkg.sv
package quad_op_reg_pkg;

  localparam int OP_SEL_W = 2;

  typedef enum logic [OP_SEL_W-1:0] {
    OP_ADD3 = 2'b00,
    OP_SHL  = 2'b01,
    OP_INV  = 2'b10,
    OP_SHR  = 2'b11
  } opCode_e;

  typedef struct packed {
    logic doAdd;
    logic doShl;
    logic doInv;
    logic doShr;
  } opStrobe_t;

endpackage

// File: rtl/quad_op_reg_ctrl.sv
module quad_op_reg_ctrl
  import quad_op_reg_pkg::*;
(
  input  logic [OP_SEL_W-1:0] opSel,
  output opStrobe_t           strobes
);

  opCode_e opCode;

  assign opCode = opCode_e'(opSel);

  always_comb begin
    strobes = '0;
    unique case (opCode)
      OP_ADD3: strobes.doAdd = 1'b1;
      OP_SHL:  strobes.doShl = 1'b1;
      OP_INV:  strobes.doInv = 1'b1;
      OP_SHR:  strobes.doShr = 1'b1;
      default: strobes.doAdd = 1'b1;
    endcase
  end

endmodule

// File: rtl/quad_op_reg_dp.sv
module quad_op_reg_dp
  import quad_op_reg_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int ADD_CONST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  opStrobe_t        strobes,
  input  logic             serInLeft,
  input  logic             serInRight,
  output logic [WIDTH-1:0] regOut
);

  localparam logic [WIDTH-1:0] ADD_VAL = WIDTH'(ADD_CONST);

  logic [WIDTH-1:0] curVal;
  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] towardMsb;
  logic [WIDTH-1:0] towardLsb;
  logic [WIDTH-1:0] nextVal;

  // Sum truncated to WIDTH bits: the carry out is simply dropped.
  assign sumVal = curVal + ADD_VAL;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign towardMsb[i] = serInRight;
    end else begin : g_mid_up
      assign towardMsb[i] = curVal[i-1];
    end
    if (i == WIDTH - 1) begin : g_msb
      assign towardLsb[i] = serInLeft;
    end else begin : g_mid_dn
      assign towardLsb[i] = curVal[i+1];
    end
  end

  always_comb begin
    nextVal = sumVal;
    if (strobes.doShl) nextVal = towardMsb;
    if (strobes.doInv) nextVal = ~curVal;
    if (strobes.doShr) nextVal = towardLsb;
  end

  always_ff @(posedge clk) begin
    if (rst) curVal <= '0;
    else     curVal <= nextVal;
  end

  assign regOut = curVal;

endmodule

// File: rtl/quad_op_reg.sv
module quad_op_reg
  import quad_op_reg_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int ADD_CONST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       opSel,
  input  logic             serInLeft,
  input  logic             serInRight,
  output logic [WIDTH-1:0] regOut
);

  opStrobe_t opStrobe;

  quad_op_reg_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (opStrobe)
  );

  quad_op_reg_dp #(
    .WIDTH     (WIDTH),
    .ADD_CONST (ADD_CONST)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (opStrobe),
    .serInLeft  (serInLeft),
    .serInRight (serInRight),
    .regOut     (regOut)
  );

endmodule

// File: rtl/quad_op_reg_checker.sv
module quad_op_reg_checker
  import quad_op_reg_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int ADD_CONST = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       opSel,
  input logic             serInLeft,
  input logic             serInRight,
  input logic [WIDTH-1:0] regOut,
  input opStrobe_t        strobes
);

  p_clear_r1: assert property (@(posedge clk)
    rst |=> regOut == '0);

  p_add_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (opSel == 2'b00) |=> regOut == WIDTH'($past(regOut) + WIDTH'(ADD_CONST)));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (rst)
    (opSel == 2'b01) |=> regOut == {$past(regOut[WIDTH-2:0]), $past(serInRight)});

  p_invert_r4: assert property (@(posedge clk) disable iff (rst)
    (opSel == 2'b10) |=> regOut == ~$past(regOut));

  p_shift_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (opSel == 2'b11) |=> regOut == {$past(serInLeft), $past(regOut[WIDTH-1:1])});

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.doAdd, strobes.doShl, strobes.doInv, strobes.doShr}) == 1);

endmodule

bind quad_op_reg quad_op_reg_checker #(
  .WIDTH     (WIDTH),
  .ADD_CONST (ADD_CONST)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opSel      (opSel),
  .serInLeft  (serInLeft),
  .serInRight (serInRight),
  .regOut     (regOut),
  .strobes    (opStrobe)
);

// File: tb/quad_op_reg_bench.sv
module quad_op_reg_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] val;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] opSel = 2'b00;
  logic       serInLeft = 1'b0;
  logic       serInRight = 1'b0;
  logic [3:0] regOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [3:0] model = 4'd0;
  expItem_t expQ[$];

  quad_op_reg u_quad_op_reg (
    .clk        (clk),
    .rst        (rst),
    .opSel      (opSel),
    .serInLeft  (serInLeft),
    .serInRight (serInRight),
    .regOut     (regOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] refNext(logic [3:0] cur, logic [1:0] code,
                                         logic sl, logic sr);
    case (code)
      2'b00:   return cur + 4'd3;
      2'b01:   return {cur[2:0], sr};
      2'b10:   return ~cur;
      default: return {sl, cur[3:1]};
    endcase
  endfunction

  // Driver: present inputs on the falling edge and queue the result expected after the next rise.
  task automatic driveOp(logic [1:0] code, logic sl, logic sr, string tag);
    expItem_t it;
    @(negedge clk);
    rst = 1'b0;
    opSel = code;
    serInLeft = sl;
    serInRight = sr;
    model = refNext(model, code, sl, sr);
    it.val = model;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic driveReset(logic [1:0] code, string tag);
    expItem_t it;
    @(negedge clk);
    rst = 1'b1;
    opSel = code;
    serInLeft = 1'b1;
    serInRight = 1'b1;
    model = 4'd0;
    it.val = 4'd0;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Build a value by four shifts toward the MSB, MSB first.
  task automatic loadVal(logic [3:0] v);
    for (int b = 3; b >= 0; b--) driveOp(2'b01, 1'b0, v[b], "R3");
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        testsRun++;
        if (regOut !== it.val) begin
          testsFailed++;
          $display("FAIL %s: regOut=%b expected=%b", it.tag, regOut, it.val);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then reset winning over every operation code
    driveReset(2'b00, "R1");
    driveReset(2'b00, "R1");
    loadVal(4'b1011);
    for (int c = 0; c < 4; c++) begin
      driveOp(2'b10, 1'b0, 1'b0, "R4");
      driveReset(2'(c), "R1");
    end

    // R2: add three from every start value, covering the wrap at 13..15
    for (int v = 0; v < 16; v++) begin
      loadVal(4'(v));
      driveOp(2'b00, 1'b0, 1'b0, "R2");
      driveOp(2'b00, 1'b1, 1'b1, "R2 R6");
    end

    // R3 and R5: walking patterns in both directions
    loadVal(4'b0000);
    for (int k = 0; k < 5; k++) driveOp(2'b01, 1'b0, (k == 0), "R3");
    for (int k = 0; k < 5; k++) driveOp(2'b11, (k == 0), 1'b0, "R5");
    loadVal(4'b1001);
    driveOp(2'b11, 1'b1, 1'b0, "R5");
    driveOp(2'b11, 1'b0, 1'b1, "R5 R6");

    // R4: invert from several values, twice to return
    for (int v = 0; v < 16; v += 5) begin
      loadVal(4'(v));
      driveOp(2'b10, 1'b1, 1'b0, "R4 R6");
      driveOp(2'b10, 1'b0, 1'b1, "R4 R6");
    end

    // R6: unused serial input toggled while the other is held
    loadVal(4'b0110);
    driveOp(2'b01, 1'b1, 1'b0, "R6");
    driveOp(2'b01, 1'b0, 1'b0, "R6");
    driveOp(2'b11, 1'b0, 1'b1, "R6");
    driveOp(2'b11, 1'b0, 1'b0, "R6");

    // R7: a different code on every consecutive edge
    loadVal(4'b0101);
    for (int k = 0; k < 12; k++) driveOp(2'(k % 4), k[0], k[1], "R7");
    for (int k = 0; k < 12; k++) driveOp(2'(3 - (k % 4)), k[1], k[0], "R7");

    @(negedge clk);
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule